// File: doc/BRIEF.md
# Retiming Elastic Buffer

This block retimes a serial NRZ transmit bit stream from the clock recovered from the incoming data onto the local reference clock. Bits are written into a small circular store on the recovered (write) clock and read out on the reference clock. The read side keeps itself a fixed distance behind the write side. Slow, bounded phase wander between the two clocks therefore moves the distance up and down without corrupting data. If the wander grows large enough that the read side would catch up with the writer, or the writer would lap the reader, a sticky wander error is raised.

The read position is re-established at mid-depth (recentered) on three events: a rising edge of a software recenter request, a high-to-low change of the transmit loss-of-lock status, and any change of the static mode select. A recenter also clears the error. When the incoming data is not source-synchronous to the reference (plesiochronous use), the mode select routes the input straight to the output and the buffer is ignored.

The store is 1 bit wide and 10 entries deep by default. The write pointer crosses into the reference domain as Gray code through a two-flop synchronizer. Occupancy and errors are judged in the reference domain.

Top module: `retime_elastic_fifo`

## Requirements
- R1: While the reference reset is low, `wander_err` is 0 and, with `retime_en`=1, `dout` is 0. After both resets are released with matched clock rates, no error is reported.
- R2: With `retime_en`=1 and equal write and reference clock rates, `dout` reproduces the `din` sequence bit for bit with a constant latency in reference cycles, and `wander_err` stays 0. The write pointer changes exactly one Gray bit per write clock.
- R3: When the write clock runs slower than the reference (9.0 ns against 8.0 ns), the observed occupancy reaches 0 and `wander_err` becomes 1 within 200 reference cycles of a recenter (underflow).
- R4: When the write clock runs faster than the reference (7.0 ns against 8.0 ns), the observed occupancy reaches depth minus the synchronizer lag and `wander_err` becomes 1 within 200 reference cycles of a recenter (overflow).
- R5: Once set, `wander_err` stays 1 after the wander stops, until a recenter or reset.
- R6: A 0-to-1 change on `sw_recenter` causes a recenter on the third reference edge after it. That edge clears `wander_err` and forces `dout` to 0 for exactly one reference cycle. Normal data resumes on the next cycle.
- R7: A 1-to-0 change on `tx_lol` causes a recenter that clears `wander_err`. A 0-to-1 change on `tx_lol` has no effect on `wander_err`.
- R8: Any change of `retime_en` causes a recenter that clears `wander_err`.
- R9: With `retime_en`=0 (bypass), `dout` equals `din` with no clock in between. `wander_err` never becomes set in bypass, even under heavy wander.
- R10: After a recenter, cumulative wander of up to 2 bit periods in either direction does not set `wander_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock of the incoming data (write side) |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| din | input | 1 | Serial NRZ data, valid on wr_clk rising edges |
| ref_clk | input | 1 | Local reference clock (read side) |
| ref_rst_n | input | 1 | Asynchronous active-low reset, read side |
| retime_en | input | 1 | Static mode: 1 = retime through buffer, 0 = bypass |
| sw_recenter | input | 1 | Software recenter request, acts on its rising edge |
| tx_lol | input | 1 | Transmit loss-of-lock status; its falling edge recenters |
| dout | output | 1 | Retimed data (ref_clk) or bypassed din |
| wander_err | output | 1 | Sticky overflow/underflow flag (ref_clk domain) |

## Verification
A recenter and an occupancy violation can land in the same reference cycle. The recenter must win: the error is cleared and not set again from the stale pointer distance. This is provoked by letting the write clock drift until the error is set and the distance is far outside its window. A loss-of-lock release or a mode change is then applied while the violation persists. The check is that `wander_err` reads 0 a few cycles later and stays 0 once the clocks match again. The recenter and the one-cycle output blanking are also checked cycle-exactly against a constant-1 input stream.

// File: rtl/rt_pkg.sv
package rt_pkg;

  // Operating mode of the output path
  typedef enum logic {
    MODE_BYPASS = 1'b0,
    MODE_RETIME = 1'b1
  } rt_mode_e;

endpackage

// File: rtl/rt_sync.sv
// Two-flop synchronizer with a selectable reset value. Also used as a
// reset synchronizer (d tied high): asserts asynchronously, releases on clk.
module rt_sync #(
  parameter int           W  = 1,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RV;
      s2_q <= RV;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/rt_wr_side.sv
// Write side: lap-counting pointer, bit store, Gray-coded pointer export.
module rt_wr_side #(
  parameter int DEPTH = 10,
  parameter int PW    = 5,
  parameter int OFF   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] mem_o,
  output logic [PW-1:0]    wgray_o
);

  localparam int LAP = 2 * DEPTH;
  localparam int IW  = $clog2(DEPTH);

  logic [PW-1:0] wp_q;
  logic [PW-1:0] wp_nx;
  logic [PW-1:0] wofs;
  logic [PW-1:0] wg_q;
  logic [PW-1:0] wg_nx;
  logic [IW-1:0] widx;
  logic          run_q;

  // next-state
  always_comb begin
    wp_nx = (wp_q == PW'(LAP - 1)) ? '0 : wp_q + 1'b1;
    wofs  = wp_nx + PW'(OFF);
    wg_nx = wofs ^ (wofs >> 1);
    widx  = IW'((wp_q >= PW'(DEPTH)) ? wp_q - PW'(DEPTH) : wp_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      wg_q  <= PW'(OFF ^ (OFF >> 1));
      run_q <= 1'b0;
    end else begin
      wp_q  <= wp_nx;
      wg_q  <= wg_nx;
      run_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic we;
    logic cell_q;
    assign we = (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cell_q <= 1'b0;
      else if (we) cell_q <= din;
    end
    assign mem_o[g] = cell_q;
  end

  assign wgray_o = wg_q;

  // R2: exported pointer moves by exactly one Gray bit per write clock
  p_gray_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ($countones(wg_q ^ $past(wg_q)) == 1));

endmodule

// File: rtl/rt_recenter.sv
// Turns the three recenter sources (already in the reference domain) into
// a one-cycle pulse; also fires once on the first cycle after reset.
module rt_recenter (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_s,
  input  logic lol_s,
  input  logic mode_s,
  output logic rc_o
);

  logic sw_d;
  logic lol_d;
  logic mode_d;
  logic started_q;

  always_comb begin
    rc_o = ~started_q
         | (sw_s & ~sw_d)
         | (lol_d & ~lol_s)
         | (mode_s ^ mode_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_d      <= 1'b0;
      lol_d     <= 1'b0;
      mode_d    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      sw_d      <= sw_s;
      lol_d     <= lol_s;
      mode_d    <= mode_s;
      started_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rt_rd_side.sv
// Read side: decodes the synchronized write pointer, keeps the read pointer
// at a fixed distance, flags wander, and registers the retimed bit.
module rt_rd_side #(
  parameter int DEPTH    = 10,
  parameter int PW       = 5,
  parameter int OFF      = 6,
  parameter int SYNC_LAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc,
  input  logic             retime,
  input  logic [DEPTH-1:0] mem_i,
  input  logic [PW-1:0]    wgray_s,
  output logic             dout_o,
  output logic             err_o
);

  localparam int LAP    = 2 * DEPTH;
  localparam int IW     = $clog2(DEPTH);
  localparam int OW     = PW + 1;
  localparam int STEADY = (DEPTH - SYNC_LAG) / 2;
  localparam int GAP    = STEADY - 1;
  localparam int OVF    = DEPTH - SYNC_LAG;

  logic [PW-1:0] wgb;
  logic [PW-1:0] wb;
  logic [PW-1:0] rp_q;
  logic [PW-1:0] rp_nx;
  logic [PW-1:0] rp_inc;
  logic [PW-1:0] rp_load;
  logic [OW-1:0] occ;
  logic [IW-1:0] ridx;
  logic          slip;
  logic          dq_q;
  logic          dq_nx;
  logic          err_q;
  logic          err_nx;

  // next-state
  always_comb begin
    wgb[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wgb[i] = wgb[i+1] ^ wgray_s[i];
    wb = wgb - PW'(OFF);

    occ = (wb >= rp_q) ? {1'b0, wb - rp_q}
                       : ({1'b0, wb} + OW'(LAP)) - {1'b0, rp_q};

    rp_inc  = (rp_q == PW'(LAP - 1)) ? '0 : rp_q + 1'b1;
    rp_load = (wb >= PW'(GAP)) ? wb - PW'(GAP) : wb + PW'(LAP - GAP);
    rp_nx   = rc ? rp_load : rp_inc;

    ridx = IW'((rp_q >= PW'(DEPTH)) ? rp_q - PW'(DEPTH) : rp_q);

    slip   = retime & ((occ == '0) | (occ >= OW'(OVF)));
    dq_nx  = rc ? 1'b0 : mem_i[ridx];
    err_nx = rc ? 1'b0 : (err_q | slip);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      dq_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rp_q  <= rp_nx;
      dq_q  <= dq_nx;
      err_q <= err_nx;
    end
  end

  assign dout_o = dq_q;
  assign err_o  = err_q;

  // R5: the error holds until a recenter arrives
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !rc) |=> err_q);

  // R6: a recenter clears the error
  p_rc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rc |=> !err_q);

  // R6: the output is blanked in the cycle after a recenter
  p_rc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rc |=> !dq_q);

  // R9: a new error is only raised while retiming was selected
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(retime));

endmodule

// File: rtl/retime_elastic_fifo.sv
module retime_elastic_fifo #(
  parameter int DEPTH    = 10,
  parameter int SYNC_LAG = 2
) (
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic din,
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic retime_en,
  input  logic sw_recenter,
  input  logic tx_lol,
  output logic dout,
  output logic wander_err
);

  import rt_pkg::*;

  localparam int LAP = 2 * DEPTH;
  localparam int PW  = $clog2(LAP);
  localparam int OFF = ((1 << PW) - LAP) / 2;
  localparam logic [PW-1:0] G0 = PW'(OFF ^ (OFF >> 1));

  logic             wr_rst_sn;
  logic             ref_rst_sn;
  logic [2:0]       ctl_s;
  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wgray;
  logic [PW-1:0]    wgray_s;
  logic             rc;
  logic             dq;
  rt_mode_e         mode;

  rt_sync #(.W(1), .RV(1'b0)) u_wr_rst (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(1'b1), .q(wr_rst_sn)
  );

  rt_sync #(.W(1), .RV(1'b0)) u_ref_rst (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(1'b1), .q(ref_rst_sn)
  );

  rt_sync #(.W(3), .RV(3'b000)) u_ctl_sync (
    .clk(ref_clk), .rst_n(ref_rst_sn),
    .d({retime_en, sw_recenter, tx_lol}), .q(ctl_s)
  );

  rt_sync #(.W(PW), .RV(G0)) u_ptr_sync (
    .clk(ref_clk), .rst_n(ref_rst_sn), .d(wgray), .q(wgray_s)
  );

  rt_wr_side #(.DEPTH(DEPTH), .PW(PW), .OFF(OFF)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_sn), .din(din),
    .mem_o(mem), .wgray_o(wgray)
  );

  rt_recenter u_rc (
    .clk(ref_clk), .rst_n(ref_rst_sn),
    .sw_s(ctl_s[1]), .lol_s(ctl_s[0]), .mode_s(ctl_s[2]),
    .rc_o(rc)
  );

  rt_rd_side #(.DEPTH(DEPTH), .PW(PW), .OFF(OFF), .SYNC_LAG(SYNC_LAG)) u_rd (
    .clk(ref_clk), .rst_n(ref_rst_sn), .rc(rc), .retime(ctl_s[2]),
    .mem_i(mem), .wgray_s(wgray_s), .dout_o(dq), .err_o(wander_err)
  );

  assign mode = rt_mode_e'(retime_en);
  assign dout = (mode == MODE_RETIME) ? dq : din;

endmodule

// File: tb/retime_elastic_fifo_bench.sv
`timescale 1ns / 1ps
module retime_elastic_fifo_bench;

  logic wr_clk;
  logic ref_clk;
  logic wr_rst_n;
  logic ref_rst_n;
  logic din;
  logic retime_en;
  logic sw_recenter;
  logic tx_lol;
  logic dout;
  logic wander_err;

  int n_chk  = 0;
  int n_fail = 0;

  realtime wr_half = 4.0;

  // din source: 0 = LFSR, 1 = constant one, 2 = manual
  int          dsel    = 0;
  logic        man_din = 1'b0;
  logic [15:0] lfsr    = 16'hACE1;
  assign din = (dsel == 0) ? lfsr[15] : (dsel == 1) ? 1'b1 : man_din;

  // stimulus table: write period (ps), run length, expected error
  localparam int VEC_N = 7;
  localparam int VEC_PER [VEC_N] = '{8000, 8080, 7920, 9000, 7000, 8500, 7600};
  localparam int VEC_CYC [VEC_N] = '{300, 200, 200, 200, 200, 200, 200};
  localparam int VEC_ERR [VEC_N] = '{0, 0, 0, 1, 1, 1, 1};
  localparam int VEC_DAT [VEC_N] = '{1, 0, 0, 0, 0, 0, 0};
  string vec_tag [VEC_N] = '{"R2", "R10", "R10", "R3", "R4", "R3", "R4"};

  bit hist [8192];
  int wcount = 0;
  bit rdat [64];
  int rwc  [64];

  retime_elastic_fifo u_retime_elastic_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .din(din),
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .retime_en(retime_en), .sw_recenter(sw_recenter), .tx_lol(tx_lol),
    .dout(dout), .wander_err(wander_err)
  );

  initial begin
    ref_clk = 1'b0;
    forever #4 ref_clk = ~ref_clk;
  end

  initial begin
    wr_clk = 1'b0;
    #1.3;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  always @(negedge wr_clk)
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge wr_clk) begin
    hist[wcount % 8192] <= din;
    wcount <= wcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_recenter();
    @(negedge ref_clk);
    sw_recenter = 1'b1;
    ref_cyc(4);
    sw_recenter = 1'b0;
  endtask

  function automatic int find_lag();
    for (int lag = 1; lag <= 24; lag++) begin
      bit all_ok;
      all_ok = 1'b1;
      for (int i = 0; i < 64; i++)
        if (hist[(rwc[i] - lag) % 8192] != rdat[i]) all_ok = 1'b0;
      if (all_ok) return lag;
    end
    return 0;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    wr_rst_n    = 1'b0;
    ref_rst_n   = 1'b0;
    retime_en   = 1'b1;
    sw_recenter = 1'b0;
    tx_lol      = 1'b0;

    // R1: reset state
    ref_cyc(5);
    check(dout == 1'b0, "R1 dout in reset", dout, 0);
    check(wander_err == 1'b0, "R1 err in reset", wander_err, 0);
    wr_rst_n  = 1'b1;
    ref_rst_n = 1'b1;
    ref_cyc(20);
    check(wander_err == 1'b0, "R1 err after release", wander_err, 0);

    // table of wander scenarios
    for (int v = 0; v < VEC_N; v++) begin
      wr_half = VEC_PER[v] / 2000.0;
      ref_cyc(5);
      pulse_recenter();
      ref_cyc(6);
      check(wander_err == 1'b0, "R6 cleared by recenter", wander_err, 0);
      if (VEC_DAT[v] != 0) begin
        for (int i = 0; i < 64; i++) begin
          @(negedge ref_clk);
          rdat[i] = dout;
          rwc[i]  = wcount;
        end
        check(find_lag() != 0, "R2 data order and latency", find_lag(), 1);
      end
      ref_cyc(VEC_CYC[v]);
      check(wander_err == VEC_ERR[v][0], vec_tag[v], wander_err, VEC_ERR[v]);
    end

    // R5: error stays after the wander stops
    wr_half = 4.0;
    ref_cyc(100);
    check(wander_err == 1'b1, "R5 sticky", wander_err, 1);

    // R6: one blanked cycle on a constant-one stream
    dsel = 1;
    ref_cyc(30);
    @(negedge ref_clk);
    sw_recenter = 1'b1;
    ref_cyc(2);
    check(dout == 1'b1, "R6 before recenter edge", dout, 1);
    ref_cyc(1);
    check(dout == 1'b0, "R6 blanked cycle", dout, 0);
    check(wander_err == 1'b0, "R6 err cleared", wander_err, 0);
    ref_cyc(1);
    check(dout == 1'b1, "R6 data resumes", dout, 1);
    sw_recenter = 1'b0;
    dsel = 0;

    // R7: loss-of-lock edges, recenter while the distance is out of range
    wr_half = 4.5;
    ref_cyc(200);
    check(wander_err == 1'b1, "R3 underflow before R7", wander_err, 1);
    wr_half = 4.0;
    tx_lol = 1'b1;
    ref_cyc(10);
    check(wander_err == 1'b1, "R7 rising lol ignored", wander_err, 1);
    tx_lol = 1'b0;
    ref_cyc(6);
    check(wander_err == 1'b0, "R7 falling lol recenters", wander_err, 0);
    ref_cyc(100);
    check(wander_err == 1'b0, "R7 stays clear", wander_err, 0);

    // R8 / R9: mode change and bypass
    wr_half = 3.5;
    ref_cyc(200);
    check(wander_err == 1'b1, "R4 overflow before R8", wander_err, 1);
    wr_half = 4.0;
    retime_en = 1'b0;
    ref_cyc(6);
    check(wander_err == 1'b0, "R8 mode change recenters", wander_err, 0);
    dsel = 2;
    for (int k = 0; k < 4; k++) begin
      man_din = (k == 1 || k == 2);
      #1;
      check(dout == man_din, "R9 bypass follows din", dout, man_din);
    end
    wr_half = 4.5;
    ref_cyc(200);
    check(wander_err == 1'b0, "R9 no error in bypass", wander_err, 0);
    wr_half = 4.0;
    dsel = 0;
    retime_en = 1'b1;
    ref_cyc(6);
    check(wander_err == 1'b0, "R8 mode back recenters", wander_err, 0);
    ref_cyc(100);
    check(wander_err == 1'b0, "R8 steady after return", wander_err, 0);

    finish_run();
  end

endmodule